// File: doc/BRIEF.md
# Line Sensor Readout Sequencer

This block runs the timing of a chain of linear photosensor sections from the host side. It makes the sensor clock by dividing the system clock, and it drives the start-of-readout pulse (called SI below) into the first section of the chain. It also gives an external converter a one-cycle pixel strobe and a pixel number. Every rule the sensor places on edge counts is handled here. Each SI is followed by enough clock edges to terminate and reset every section. The next SI never comes earlier than the first legal edge. A burst of throw-away frames clears charge that built up while the sensor sat idle.

The chain holds `DEVICES` devices, each of `SECTIONS` sections of `SEC_PIX` pixels, all wired in series. `NTOT = SEC_PIX*SECTIONS*DEVICES` pixels come out per frame. The minimum frame is `FRAME_EDGES = NTOT+1` rising sensor-clock edges, counting the edge that samples SI. The host sets the integration length in sensor clocks on `integ_len`. A `start_req` pulse begins operation and a `stop_req` pulse ends it. A `gap_seen` pulse reports that the sensor saw a stretch of inactivity, and it forces a new flush burst.

The sequencer has four states. IDLE: clock parked low. FLUSH: dummy frames at minimum length. SCAN: live frames at the programmed length. DRAIN: finish the current frame, then stop. Transitions:
- IDLE→FLUSH on `start_req`.
- FLUSH→SCAN on the SI-sampling edge once the flush count is used up.
- FLUSH→DRAIN and SCAN→DRAIN on `stop_req`.
- SCAN→FLUSH on `gap_seen`.
- DRAIN→IDLE on the falling edge after the frame's last required rising edge.

Top module: `line_sensor_ctrl`

## Requirements
- R1: After reset, `sensor_clk`, `sensor_si` and `pix_strobe` are low and `pix_index` is 0. The sensor clock stays parked low until a start request.
- R2: While running, each high phase and each low phase of `sensor_clk` lasts exactly H system clocks. H is `SCLK_DIV_REQ`, raised when needed to ceil(`SYS_CLK_HZ`/(2*`SCLK_MAX_HZ`)), so the sensor clock never runs faster than `SCLK_MAX_HZ`.
- R3: `sensor_si` changes only while `sensor_clk` is low. Each SI pulse is high for exactly 2*H system clocks and spans exactly one rising sensor-clock edge.
- R4: A start request is followed by `INIT_FRAMES` flush frames. In these frames no pixel strobe is produced, and each lasts FRAME_EDGES rising edges from its SI edge to the next SI edge.
- R5: A live frame lasts max(`integ_len`, FRAME_EDGES) rising edges from its SI edge to the next SI edge. A shorter programmed value is clamped up.
- R6: In a live frame, `pix_strobe` pulses for one system clock right after each falling sensor-clock edge that follows rising edge k of the frame (edge 1 samples SI), for k = 1..NTOT. `pix_index` equals k during that pulse, so indices run 1..NTOT in order.
- R7: After `stop_req`, no new SI is issued. The clock keeps running until the current frame has had at least FRAME_EDGES rising edges; it then parks low at the next falling edge. The strobes of the current frame all still appear.
- R8: `gap_seen` during live readout lets the current frame finish with all its strobes. The next `INIT_FRAMES` frames are then flush frames, and live frames follow.
- R9: `start_req` while running has no effect. `stop_req` and `gap_seen` while idle have no effect.
- R10: The period that ends at the first live frame of a burst (the one after the last flush frame) uses the clamped `integ_len`, so the first live frame gets the full integration time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_req | input | 1 | One-cycle request to begin flush and readout |
| stop_req | input | 1 | One-cycle request to finish the frame and park |
| gap_seen | input | 1 | One-cycle report of sensor inactivity; forces a new flush burst |
| integ_len | input | LEN_W | Integration length in sensor clocks |
| sensor_clk | output | 1 | Divided sensor clock |
| sensor_si | output | 1 | Start-of-readout pulse to the first section |
| pix_strobe | output | 1 | One-cycle pixel-valid strobe for the converter |
| pix_index | output | $clog2(NTOT+1) | Pixel number 1..NTOT, valid with the strobe |

## Verification
The bench uses two devices of two 4-pixel sections each. That gives a 16-pixel frame with a 17-edge minimum, so a full 12-frame flush burst and a flush re-run after a gap report both fit in a few thousand cycles. The rate limit is 6.25 MHz against a 50 MHz system clock. This raises the requested half period of 2 to 4, so the divider's clamp is exercised. With an 8-bit integration length, values of 5, 18 and 20 test the frame-length clamp and programmed lengths just above the minimum.

// File: rtl/lsc_pkg.sv
package lsc_pkg;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_FLUSH,
        SQ_SCAN,
        SQ_DRAIN
    } seq_state_e;

    // Half period in system clocks: the request, raised to the rate limit.
    function automatic int unsigned half_period(input int unsigned req,
                                                input int unsigned sys_hz,
                                                input int unsigned max_hz);
        int unsigned floor_half;
        floor_half = (sys_hz + 2 * max_hz - 1) / (2 * max_hz);
        if (floor_half < 1) floor_half = 1;
        return (req > floor_half) ? req : floor_half;
    endfunction

endpackage

// File: rtl/lsc_clkdiv.sv
module lsc_clkdiv #(
    parameter int DIV_HALF = 50
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_en,
    output logic sclk,
    output logic rise_tick,
    output logic fall_tick
);
    logic wrap;

    generate
        if (DIV_HALF > 1) begin : g_count
            localparam int CNT_W = $clog2(DIV_HALF);
            logic [CNT_W-1:0] cnt;

            assign wrap = run_en && (cnt == CNT_W'(DIV_HALF - 1));

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    cnt <= '0;
                end else if (!run_en || wrap) begin
                    cnt <= '0;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end else begin : g_direct
            assign wrap = run_en;
        end
    endgenerate

    assign rise_tick = wrap && !sclk;
    assign fall_tick = wrap && sclk;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk <= 1'b0;
        end else if (!run_en) begin
            sclk <= 1'b0;
        end else if (wrap) begin
            sclk <= ~sclk;
        end
    end
endmodule

// File: rtl/lsc_seq.sv
module lsc_seq import lsc_pkg::*; #(
    parameter int FRAME_EDGES = 129,
    parameter int INIT_FRAMES = 12,
    parameter int LEN_W       = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_req,
    input  logic             stop_req,
    input  logic             gap_seen,
    input  logic [LEN_W-1:0] integ_len,
    input  logic             rise_tick,
    input  logic             fall_tick,
    output logic             run_en,
    output logic             si_q,
    output logic             live,
    output logic [LEN_W-1:0] pos
);
    localparam int FL_W = $clog2(INIT_FRAMES + 1);
    localparam logic [LEN_W-1:0] MIN_LEN = LEN_W'(FRAME_EDGES);

    seq_state_e       state, state_nx;
    logic [FL_W-1:0]  flush_left;
    logic [LEN_W-1:0] per_len;
    logic [LEN_W-1:0] clamped_len;
    logic             si_edge;
    logic             issue_ok;

    assign clamped_len = (integ_len < MIN_LEN) ? MIN_LEN : integ_len;
    assign si_edge     = rise_tick && si_q;
    assign issue_ok    = (state_nx == SQ_FLUSH) || (state_nx == SQ_SCAN);
    assign run_en      = (state != SQ_IDLE);

    always_comb begin
        state_nx = state;
        unique case (state)
            SQ_IDLE:  if (start_req) state_nx = SQ_FLUSH;
            SQ_FLUSH: begin
                if (stop_req)
                    state_nx = SQ_DRAIN;
                else if (si_edge && flush_left == '0 && !gap_seen)
                    state_nx = SQ_SCAN;
            end
            SQ_SCAN: begin
                if (stop_req)      state_nx = SQ_DRAIN;
                else if (gap_seen) state_nx = SQ_FLUSH;
            end
            SQ_DRAIN: begin
                if (fall_tick && !si_q && pos >= MIN_LEN) state_nx = SQ_IDLE;
            end
            default: state_nx = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= SQ_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            si_q       <= 1'b0;
            live       <= 1'b0;
            pos        <= '0;
            per_len    <= MIN_LEN;
            flush_left <= '0;
        end else if (state == SQ_IDLE) begin
            live <= 1'b0;
            if (start_req) begin
                si_q       <= 1'b1;
                pos        <= '0;
                flush_left <= FL_W'(INIT_FRAMES);
            end
        end else begin
            if (rise_tick) begin
                if (si_q) begin
                    pos  <= LEN_W'(1);
                    live <= (flush_left == '0);
                    if (flush_left != '0) flush_left <= flush_left - 1'b1;
                    per_len <= (flush_left <= FL_W'(1)) ? clamped_len : MIN_LEN;
                end else begin
                    pos <= pos + 1'b1;
                end
            end
            if (fall_tick) begin
                if (si_q)
                    si_q <= 1'b0;
                else if (issue_ok && pos >= per_len)
                    si_q <= 1'b1;
            end
            if (gap_seen && state_nx == SQ_FLUSH)
                flush_left <= FL_W'(INIT_FRAMES);
        end
    end
endmodule

// File: rtl/lsc_pixout.sv
module lsc_pixout #(
    parameter int NTOT  = 128,
    parameter int LEN_W = 16,
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fall_tick,
    input  logic             live,
    input  logic [LEN_W-1:0] pos,
    output logic             pix_strobe,
    output logic [IDX_W-1:0] pix_index
);
    logic in_window;

    assign in_window = (pos != '0) && (pos <= LEN_W'(NTOT));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pix_strobe <= 1'b0;
            pix_index  <= '0;
        end else begin
            pix_strobe <= fall_tick && live && in_window;
            if (fall_tick && live && in_window)
                pix_index <= IDX_W'(pos);
        end
    end
endmodule

// File: rtl/line_sensor_ctrl.sv
module line_sensor_ctrl import lsc_pkg::*; #(
    parameter int          SEC_PIX      = 64,
    parameter int          SECTIONS     = 2,
    parameter int          DEVICES      = 1,
    parameter int          INIT_FRAMES  = 12,
    parameter int          LEN_W        = 16,
    parameter int unsigned SYS_CLK_HZ   = 50_000_000,
    parameter int unsigned SCLK_MAX_HZ  = 500_000,
    parameter int unsigned SCLK_DIV_REQ = 50
) (
    input  logic                                        clk,
    input  logic                                        rst_n,
    input  logic                                        start_req,
    input  logic                                        stop_req,
    input  logic                                        gap_seen,
    input  logic [LEN_W-1:0]                            integ_len,
    output logic                                        sensor_clk,
    output logic                                        sensor_si,
    output logic                                        pix_strobe,
    output logic [$clog2(SEC_PIX*SECTIONS*DEVICES+1)-1:0] pix_index
);
    localparam int NTOT        = SEC_PIX * SECTIONS * DEVICES;
    localparam int FRAME_EDGES = NTOT + 1;
    localparam int IDX_W       = $clog2(NTOT + 1);
    localparam int DIV_HALF    = int'(half_period(SCLK_DIV_REQ, SYS_CLK_HZ, SCLK_MAX_HZ));

    logic             run_en;
    logic             rise_tick;
    logic             fall_tick;
    logic             live;
    logic [LEN_W-1:0] pos;

    lsc_clkdiv #(.DIV_HALF(DIV_HALF)) u_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_en    (run_en),
        .sclk      (sensor_clk),
        .rise_tick (rise_tick),
        .fall_tick (fall_tick)
    );

    lsc_seq #(
        .FRAME_EDGES (FRAME_EDGES),
        .INIT_FRAMES (INIT_FRAMES),
        .LEN_W       (LEN_W)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_req (start_req),
        .stop_req  (stop_req),
        .gap_seen  (gap_seen),
        .integ_len (integ_len),
        .rise_tick (rise_tick),
        .fall_tick (fall_tick),
        .run_en    (run_en),
        .si_q      (sensor_si),
        .live      (live),
        .pos       (pos)
    );

    lsc_pixout #(
        .NTOT  (NTOT),
        .LEN_W (LEN_W),
        .IDX_W (IDX_W)
    ) u_pix (
        .clk        (clk),
        .rst_n      (rst_n),
        .fall_tick  (fall_tick),
        .live       (live),
        .pos        (pos),
        .pix_strobe (pix_strobe),
        .pix_index  (pix_index)
    );
endmodule

// File: rtl/lsc_checker.sv
module lsc_checker #(
    parameter int DIV_HALF    = 50,
    parameter int FRAME_EDGES = 129,
    parameter int NTOT        = 128,
    parameter int IDX_W       = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             run_en,
    input logic             sensor_clk,
    input logic             sensor_si,
    input logic             pix_strobe,
    input logic [IDX_W-1:0] pix_index
);
    logic        sclk_d;
    logic [15:0] hcnt;
    logic [15:0] rise_cnt;
    logic        sclk_edge;
    logic        sclk_rise;

    assign sclk_edge = (sensor_clk != sclk_d);
    assign sclk_rise = sclk_edge && sensor_clk;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_d   <= 1'b0;
            hcnt     <= '0;
            rise_cnt <= '0;
        end else begin
            sclk_d <= sensor_clk;
            if (sclk_edge)             hcnt <= 16'd1;
            else if (hcnt != 16'hFFFF) hcnt <= hcnt + 16'd1;
            if (sclk_rise) begin
                if (sensor_si)                 rise_cnt <= 16'd1;
                else if (rise_cnt != 16'hFFFF) rise_cnt <= rise_cnt + 16'd1;
            end
        end
    end

    a_r2_high_phase: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk_edge && !sensor_clk) |-> (hcnt == 16'(DIV_HALF)));

    a_r2_low_phase: assert property (@(posedge clk) disable iff (!rst_n)
        sclk_rise |-> (hcnt >= 16'(DIV_HALF)));

    a_r3_si_moves_on_low: assert property (@(posedge clk) disable iff (!rst_n)
        $changed(sensor_si) |-> !sensor_clk);

    a_r5_si_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk_rise && sensor_si) |-> (rise_cnt == '0 || rise_cnt >= 16'(FRAME_EDGES)));

    a_r6_strobe_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
        pix_strobe |-> (sclk_edge && !sensor_clk));

    a_r6_strobe_range: assert property (@(posedge clk) disable iff (!rst_n)
        pix_strobe |-> (pix_index != '0 && pix_index <= IDX_W'(NTOT)));

    a_r6_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
        pix_strobe |=> !pix_strobe);

    a_r7_drain_edges: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(run_en) |-> (rise_cnt >= 16'(FRAME_EDGES)));

    a_r7_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |-> (!sensor_clk && !sensor_si && !pix_strobe));
endmodule

bind line_sensor_ctrl lsc_checker #(
    .DIV_HALF    (DIV_HALF),
    .FRAME_EDGES (FRAME_EDGES),
    .NTOT        (NTOT),
    .IDX_W       (IDX_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .run_en     (run_en),
    .sensor_clk (sensor_clk),
    .sensor_si  (sensor_si),
    .pix_strobe (pix_strobe),
    .pix_index  (pix_index)
);

// File: tb/tb_line_sensor_ctrl.sv
`timescale 1ns/1ps
module tb_line_sensor_ctrl;
    localparam int SEC_PIX = 4;
    localparam int SECTIONS = 2;
    localparam int DEVICES = 2;
    localparam int INIT = 12;
    localparam int LEN_W = 8;
    localparam int NTOT = SEC_PIX * SECTIONS * DEVICES;
    localparam int FE = NTOT + 1;
    localparam int IDX_W = $clog2(NTOT + 1);
    localparam int H = 4;   // expected half period: request 2 raised to the 6.25 MHz limit

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_req = 1'b0, stop_req = 1'b0, gap_seen = 1'b0;
    logic [LEN_W-1:0] integ_len = '0;
    logic sensor_clk, sensor_si, pix_strobe;
    logic [IDX_W-1:0] pix_index;

    int checks = 0;
    int failures = 0;

    always #10 clk = ~clk;

    line_sensor_ctrl #(
        .SEC_PIX(SEC_PIX), .SECTIONS(SECTIONS), .DEVICES(DEVICES),
        .INIT_FRAMES(INIT), .LEN_W(LEN_W),
        .SYS_CLK_HZ(50_000_000), .SCLK_MAX_HZ(6_250_000), .SCLK_DIV_REQ(2)
    ) dut (
        .clk(clk), .rst_n(rst_n), .start_req(start_req), .stop_req(stop_req),
        .gap_seen(gap_seen), .integ_len(integ_len), .sensor_clk(sensor_clk),
        .sensor_si(sensor_si), .pix_strobe(pix_strobe), .pix_index(pix_index)
    );

    // Monitor state, sampled on the falling system-clock edge
    logic p_sclk = 1'b0, p_si = 1'b0;
    int phase_len = 0, si_len = 0, si_hi_rises = 0;
    int si_count = 0, since_si = 0, exp_idx = 1, rise_tot = 0;
    int hi_bad = 0, lo_bad = 0, si_bad = 0, idx_bad = 0;
    int gaps [0:63];
    int fstrobe [0:63];

    always @(negedge clk) begin
        if (sensor_clk != p_sclk) begin
            if (p_sclk) begin
                if (phase_len != H) hi_bad++;
            end else begin
                if (phase_len < 40 && phase_len != H) lo_bad++;
                rise_tot++;
                if (sensor_si) begin
                    si_hi_rises++;
                    if (si_count > 0 && si_count <= 64) gaps[si_count-1] = since_si;
                    si_count++;
                    since_si = 1;
                    exp_idx = 1;
                end else begin
                    since_si++;
                end
            end
            phase_len = 1;
        end else if (phase_len < 1000) begin
            phase_len++;
        end
        if (sensor_si) begin
            si_len++;
        end else if (p_si) begin
            if (si_len != 2 * H || si_hi_rises != 1) si_bad++;
            si_len = 0;
            si_hi_rises = 0;
        end
        if (pix_strobe) begin
            if (sensor_clk) idx_bad++;
            if (int'(pix_index) != exp_idx) idx_bad++;
            exp_idx++;
            if (si_count > 0 && si_count <= 64) fstrobe[si_count-1]++;
        end
        p_sclk = sensor_clk;
        p_si = sensor_si;
    end

    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    task automatic mon_clear();
        for (int i = 0; i < 64; i++) begin
            gaps[i] = 0;
            fstrobe[i] = 0;
        end
        si_count = 0; since_si = 0; exp_idx = 1;
        hi_bad = 0; lo_bad = 0; si_bad = 0; idx_bad = 0;
    endtask

    task automatic pulse(input int which);
        @(posedge clk); #1;
        if (which == 0) start_req = 1'b1;
        else if (which == 1) stop_req = 1'b1;
        else gap_seen = 1'b1;
        @(posedge clk); #1;
        start_req = 1'b0; stop_req = 1'b0; gap_seen = 1'b0;
    endtask

    task automatic wait_si(input int n);
        int t;
        t = 0;
        while (si_count < n && t < 30000) begin
            @(posedge clk);
            t++;
        end
        chk(si_count >= n, "R4 frame progress", si_count, n);
    endtask

    task automatic wait_quiet();
        int t;
        t = 0;
        while (!(sensor_clk == 1'b0 && phase_len >= 40) && t < 30000) begin
            @(posedge clk);
            t++;
        end
        chk(sensor_clk == 1'b0, "R7 clock parked", int'(sensor_clk), 0);
    endtask

    function automatic int bad_gaps(input int lo, input int hi, input int exp);
        int n;
        n = 0;
        for (int i = lo; i <= hi; i++) if (gaps[i] != exp) n++;
        return n;
    endfunction

    function automatic int strobe_sum(input int lo, input int hi);
        int n;
        n = 0;
        for (int i = lo; i <= hi; i++) n += fstrobe[i];
        return n;
    endfunction

    task automatic t_reset_idle();
        int r0;
        #1;
        chk(sensor_clk == 1'b0 && sensor_si == 1'b0, "R1 clk/si low in reset", int'({sensor_clk, sensor_si}), 0);
        rst_n = 1'b1;
        repeat (5) @(posedge clk);
        #1;
        chk(pix_strobe == 1'b0 && pix_index == '0, "R1 strobe/index idle", int'(pix_index), 0);
        r0 = rise_tot;
        pulse(1);
        pulse(2);
        repeat (100) @(posedge clk);
        #1;
        chk(rise_tot == r0 && sensor_si == 1'b0, "R9 stop/gap ignored when idle", rise_tot - r0, 0);
    endtask

    task automatic t_normal();
        int r0;
        mon_clear();
        integ_len = 8'd20;
        pulse(0);
        wait_si(INIT + 3);
        repeat (40) @(posedge clk);
        pulse(1);
        wait_quiet();
        chk(strobe_sum(0, INIT - 1) == 0, "R4 no strobes in flush frames", strobe_sum(0, INIT - 1), 0);
        chk(bad_gaps(0, INIT - 2, FE) == 0, "R4 flush frame length", gaps[0], FE);
        chk(gaps[INIT-1] == 20, "R10 period before first live frame", gaps[INIT-1], 20);
        chk(bad_gaps(INIT, INIT + 1, 20) == 0, "R5 live frame length", gaps[INIT], 20);
        chk(fstrobe[INIT] == NTOT && fstrobe[INIT+1] == NTOT, "R6 strobes per live frame", fstrobe[INIT], NTOT);
        chk(idx_bad == 0, "R6 index order and strobe timing", idx_bad, 0);
        chk(fstrobe[INIT+2] == NTOT, "R7 drained frame completes", fstrobe[INIT+2], NTOT);
        chk(since_si == FE, "R7 edges after last SI", since_si, FE);
        chk(si_count == INIT + 3, "R7 no SI after stop", si_count, INIT + 3);
        chk(hi_bad == 0 && lo_bad == 0, "R2 phase length", hi_bad + lo_bad, 0);
        chk(si_bad == 0, "R3 SI width and single edge", si_bad, 0);
        r0 = rise_tot;
        repeat (100) @(posedge clk);
        chk(rise_tot == r0, "R7 clock stays parked", rise_tot - r0, 0);
    endtask

    task automatic t_clamp();
        mon_clear();
        integ_len = 8'd5;
        pulse(0);
        wait_si(INIT + 2);
        pulse(0);
        wait_si(INIT + 4);
        pulse(1);
        wait_quiet();
        chk(gaps[INIT-1] == FE, "R5 clamp before first live frame", gaps[INIT-1], FE);
        chk(bad_gaps(INIT, INIT + 2, FE) == 0, "R5 clamped live length", gaps[INIT], FE);
        chk(strobe_sum(INIT, INIT + 3) == 4 * NTOT, "R9 start while running ignored", strobe_sum(INIT, INIT + 3), 4 * NTOT);
        chk(strobe_sum(0, INIT - 1) == 0, "R4 flush silent", strobe_sum(0, INIT - 1), 0);
        chk(si_bad == 0 && idx_bad == 0, "R3 SI shape in clamp run", si_bad + idx_bad, 0);
    endtask

    task automatic t_gap();
        mon_clear();
        integ_len = 8'd18;
        pulse(0);
        wait_si(INIT + 2);
        repeat (40) @(posedge clk);
        pulse(2);
        wait_si(2 * INIT + 4);
        pulse(1);
        wait_quiet();
        chk(fstrobe[INIT+1] == NTOT, "R8 current frame finishes", fstrobe[INIT+1], NTOT);
        chk(strobe_sum(INIT + 2, 2 * INIT + 1) == 0, "R8 re-flush frames silent", strobe_sum(INIT + 2, 2 * INIT + 1), 0);
        chk(fstrobe[2*INIT+2] == NTOT, "R8 live frames resume", fstrobe[2*INIT+2], NTOT);
        chk(gaps[INIT+1] == 18, "R5 live period before re-flush", gaps[INIT+1], 18);
        chk(bad_gaps(INIT + 2, 2 * INIT, FE) == 0, "R8 re-flush frame length", gaps[INIT+2], FE);
        chk(gaps[2*INIT+1] == 18, "R10 period before resumed live frame", gaps[2*INIT+1], 18);
        chk(idx_bad == 0 && hi_bad == 0, "R6 index order after gap", idx_bad + hi_bad, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog all-requirements actual=timeout expected=completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        t_reset_idle();
        t_normal();
        t_clamp();
        t_gap();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule